// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer with Waveform Output

This block is an 8-bit up-counter with one compare channel that drives a single waveform pin. A 2-bit mode code picks one of four generation schemes: free-running overflow counting, clear-on-compare period counting, single-slope fast PWM and dual-slope phase-correct PWM. The mode sets the counter's TOP, the moment a new compare value becomes active, and the count at which the overflow flag is raised.

The counter only advances on cycles where the `tick` input is high, so an external prescaler sets the count rate. Software-style writes to the compare value come in on a plain write strobe with no back-pressure: the write is always accepted in the cycle it is presented, and the mode decides whether it acts at once or waits for TOP. A 2-bit output mode code chooses how the compare match and TOP drive the waveform pin, and a separate enable tells the pad logic to let the waveform replace the pin's normal function. Two sticky flags report overflow and compare match until their clear inputs are pulsed.

Top module: `wavetimer8`

## Requirements
- R1: The count changes only on cycles with `tick` high. In mode 00 (free-running) and mode 11 (fast PWM) it rises by one per tick and goes from 0xFF to 0x00.
- R2: In mode 10 (clear on compare) a tick taken while the count equals the active compare value loads 0x00. Any other tick adds one.
- R3: In mode 01 (phase-correct) the count rises from 0x00 to 0xFF, then falls to 0x00, then rises again. The tick at 0xFF loads 0xFE and the tick at 0x00 while falling loads 0x01.
- R4: A compare write in modes 00 and 10 sets the active compare value on the next clock. In modes 01 and 11 the write only fills a holding register, which is copied to the active value on the tick at which the count is 0xFF.
- R5: The overflow flag is set by a tick at count 0xFF in modes 00, 10 and 11. In mode 01 it is set by a tick at count 0x00.
- R6: The match flag is set by a tick at which the count equals the active compare value. Both flags stay set until their clear input is high for a cycle. A set in the same cycle as a clear wins.
- R7: In modes 00 and 10, a match tick acts on the output by output mode: 01 inverts it, 10 drives it to 0, 11 drives it to 1, and 00 leaves it unchanged.
- R8: In mode 11 with output mode 10, a match tick drives the output to 0 and a tick at 0xFF drives it to 1. Output mode 11 does the opposite. Output modes 00 and 01 leave the output unchanged.
- R9: In mode 11, when a tick at count 0xFF is also a match (compare value 0xFF), only the action for 0xFF is taken.
- R10: In mode 01 with output mode 10, a match on the rising slope drives the output to 0 and a match on the falling slope drives it to 1. Output mode 11 does the opposite. Output modes 00 and 01 leave the output unchanged.
- R11: `wave_en` is high exactly when the output mode is not 00.
- R12: Synchronous reset clears the count, the active and held compare values, both flags and the waveform output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from prescaler |
| mode_sel | input | 2 | Generation mode: 00 free-run, 01 phase-correct, 10 clear on compare, 11 fast PWM |
| out_mode | input | 2 | Waveform output action code |
| cmp_wr_en | input | 1 | Compare write strobe, always accepted |
| cmp_wr_data | input | 8 | Compare write value |
| ovf_clr | input | 1 | Clears the overflow flag |
| match_clr | input | 1 | Clears the match flag |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform output |
| wave_en | output | 1 | Waveform replaces pin function |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
A wrong slope bit in phase-correct mode shows up on `count` at the next turning point. It also inverts the set or clear action at the next match, so `wave_out` is wrong within one period of 510 ticks. An active compare value loaded at the wrong moment shows in fast PWM as a pulse edge at the old position for a whole period before it corrects itself. In clear-on-compare mode the count goes one past the old compare value on the very next tick. A flag that loses to its clear or misses its set tick is visible on the flag pin one clock later. The bench runs each mode for one or two full periods so these faults reach the pins.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_PHASE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_FAST  = 2'b11
  } tmr_mode_e;

  function automatic logic mode_is_pwm(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = tmr8_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] cnt,
  output logic         falling
);
  import tmr8_pkg::*;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ZERO;
      falling <= 1'b0;
    end else begin
      if (mode != MODE_PHASE) falling <= 1'b0;
      if (tick) begin
        case (mode)
          MODE_CLEAR: cnt <= (cnt == cmp_act) ? ZERO : cnt + ONE;
          MODE_PHASE: begin
            if (!falling) begin
              if (cnt == MAXV) begin
                falling <= 1'b1;
                cnt     <= MAXV - ONE;
              end else begin
                cnt <= cnt + ONE;
              end
            end else begin
              if (cnt == ZERO) begin
                falling <= 1'b0;
                cnt     <= ONE;
              end else begin
                cnt <= cnt - ONE;
              end
            end
          end
          default: cnt <= cnt + ONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr8_cmpreg.sv
module tmr8_cmpreg #(
  parameter int W = tmr8_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cnt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_act
);
  import tmr8_pkg::*;
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cmp_hold;
  logic         at_top_tick;

  assign at_top_tick = tick && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_hold <= '0;
      cmp_act  <= '0;
    end else begin
      if (wr_en) cmp_hold <= wr_data;
      if (mode_is_pwm(mode)) begin
        if (at_top_tick) cmp_act <= cmp_hold;
      end else if (wr_en) begin
        cmp_act <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen #(
  parameter int W = tmr8_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [1:0]   out_mode,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_act,
  input  logic         falling,
  output logic         wave
);
  import tmr8_pkg::*;
  localparam logic [W-1:0] MAXV = '1;

  logic hit, at_top, wave_nx;

  assign hit    = (cnt == cmp_act);
  assign at_top = (cnt == MAXV);

  always_comb begin
    wave_nx = wave;
    case (mode)
      MODE_FAST: begin
        if (out_mode[1]) begin
          if (at_top)   wave_nx = ~out_mode[0];
          else if (hit) wave_nx = out_mode[0];
        end
      end
      MODE_PHASE: begin
        if (out_mode[1] && hit) wave_nx = falling ? ~out_mode[0] : out_mode[0];
      end
      default: begin
        if (hit) begin
          case (out_mode)
            2'b01:   wave_nx = ~wave;
            2'b10:   wave_nx = 1'b0;
            2'b11:   wave_nx = 1'b1;
            default: wave_nx = wave;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       wave <= 1'b0;
    else if (tick) wave <= wave_nx;
  end
endmodule

// File: rtl/wavetimer8.sv
module wavetimer8 #(
  parameter int W = tmr8_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   out_mode,
  input  logic         cmp_wr_en,
  input  logic [W-1:0] cmp_wr_data,
  input  logic         ovf_clr,
  input  logic         match_clr,
  output logic [W-1:0] count,
  output logic         wave_out,
  output logic         wave_en,
  output logic         ovf_flag,
  output logic         match_flag
);
  import tmr8_pkg::*;
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt, cmp_act;
  logic         falling, ovf_set, match_set;

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_sel),
    .cmp_act(cmp_act), .cnt(cnt), .falling(falling)
  );

  tmr8_cmpreg #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_sel), .cnt(cnt),
    .wr_en(cmp_wr_en), .wr_data(cmp_wr_data), .cmp_act(cmp_act)
  );

  tmr8_wavegen #(.W(W)) u_wave (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_sel), .out_mode(out_mode),
    .cnt(cnt), .cmp_act(cmp_act), .falling(falling), .wave(wave_out)
  );

  assign ovf_set   = tick && ((mode_sel == MODE_PHASE) ? (cnt == ZERO) : (cnt == MAXV));
  assign match_set = tick && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (match_set)      match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
    end
  end

  assign count   = cnt;
  assign wave_en = |out_mode;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [1:0]   mode_sel,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_act,
  input logic         wave_out,
  input logic         ovf_flag,
  input logic         ovf_clr,
  input logic         match_flag
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_sel[0] == mode_sel[1] && count == MAXV) |=> (count == ZERO));

  p_clear_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_sel == 2'b10 && count == cmp_act) |=> (count == ZERO));

  p_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_sel == 2'b01 && count == MAXV) |=> (count == MAXV - W'(1)));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_sel != 2'b01 && count == MAXV) |=> ovf_flag);

  p_match_set_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && count == cmp_act) |=> match_flag);

  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !tick) |=> !ovf_flag);

  p_wave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(wave_out));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (count == ZERO && !wave_out && !ovf_flag && !match_flag && cmp_act == ZERO));
endmodule

bind wavetimer8 tmr8_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel), .count(count),
  .cmp_act(cmp_act), .wave_out(wave_out), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .match_flag(match_flag)
);

// File: tb/sim_wavetimer8.sv
module sim_wavetimer8;
  localparam int PERIOD = 10;
  localparam int NVEC   = 16;

  typedef struct packed {
    logic [1:0]  m;
    logic [1:0]  om;
    logic [7:0]  cmp;
    logic [15:0] n;
    logic [7:0]  cnt;
    logic        wave;
    logic        ovf;
    logic        mat;
  } vec_t;

  // mode, out mode, compare, ticks, expected count, wave, ovf, match
  localparam vec_t VECS [0:NVEC-1] = '{
    '{2'd0, 2'd1, 8'h05, 16'd6,   8'h06, 1'b1, 1'b0, 1'b1}, // R7 toggle, R1
    '{2'd0, 2'd1, 8'h05, 16'd262, 8'h06, 1'b0, 1'b1, 1'b1}, // R1 wrap, R5
    '{2'd0, 2'd1, 8'hC8, 16'd10,  8'h0A, 1'b0, 1'b0, 1'b0}, // R6 no match yet
    '{2'd2, 2'd1, 8'h09, 16'd10,  8'h00, 1'b1, 1'b0, 1'b1}, // R2 wrap at compare
    '{2'd2, 2'd3, 8'h09, 16'd25,  8'h05, 1'b1, 1'b0, 1'b1}, // R2, R7 set
    '{2'd3, 2'd2, 8'h40, 16'd256, 8'h00, 1'b1, 1'b1, 1'b1}, // R8 set at 0xFF
    '{2'd3, 2'd2, 8'h40, 16'd321, 8'h41, 1'b0, 1'b1, 1'b1}, // R8 clear, R4 loaded
    '{2'd3, 2'd3, 8'h40, 16'd321, 8'h41, 1'b1, 1'b1, 1'b1}, // R8 inverted
    '{2'd3, 2'd1, 8'h40, 16'd300, 8'h2C, 1'b0, 1'b1, 1'b1}, // R8 code 01 quiet
    '{2'd3, 2'd3, 8'hFF, 16'd512, 8'h00, 1'b0, 1'b1, 1'b1}, // R9
    '{2'd3, 2'd2, 8'hFF, 16'd512, 8'h00, 1'b1, 1'b1, 1'b1}, // R9
    '{2'd1, 2'd2, 8'h40, 16'd256, 8'hFE, 1'b0, 1'b1, 1'b1}, // R3 turn
    '{2'd1, 2'd2, 8'h40, 16'd447, 8'h3F, 1'b1, 1'b1, 1'b1}, // R10 falling set
    '{2'd1, 2'd3, 8'h40, 16'd447, 8'h3F, 1'b0, 1'b1, 1'b1}, // R10 inverted
    '{2'd1, 2'd2, 8'h40, 16'd511, 8'h01, 1'b1, 1'b1, 1'b1}, // R3 bottom, R5
    '{2'd2, 2'd0, 8'hFF, 16'd256, 8'h00, 1'b0, 1'b1, 1'b1}  // R5 clear mode
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [1:0] out_mode = 2'b00;
  logic       cmp_wr_en = 1'b0;
  logic [7:0] cmp_wr_data = 8'h00;
  logic       ovf_clr = 1'b0;
  logic       match_clr = 1'b0;
  logic [7:0] count;
  logic       wave_out, wave_en, ovf_flag, match_flag;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  wavetimer8 u0 (
    .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel), .out_mode(out_mode),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data), .ovf_clr(ovf_clr),
    .match_clr(match_clr), .count(count), .wave_out(wave_out), .wave_en(wave_en),
    .ovf_flag(ovf_flag), .match_flag(match_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr_en = 1'b1; cmp_wr_data = v;
    @(negedge clk);
    cmp_wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 wave", wave_out, 0);
    chk("R12 ovf", ovf_flag, 0);
    chk("R12 match", match_flag, 0);
    chk("R11 en off", wave_en, 0);

    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      mode_sel = VECS[i].m;
      out_mode = VECS[i].om;
      write_cmp(VECS[i].cmp);
      run(int'(VECS[i].n));
      chk($sformatf("vec%0d count R1/R2/R3", i), count, VECS[i].cnt);
      chk($sformatf("vec%0d wave R7/R8/R9/R10", i), wave_out, VECS[i].wave);
      chk($sformatf("vec%0d ovf R5", i), ovf_flag, VECS[i].ovf);
      chk($sformatf("vec%0d match R6", i), match_flag, VECS[i].mat);
      chk($sformatf("vec%0d enable R11", i), wave_en, (VECS[i].om != 2'b00));
    end

    // R1 no advance without tick
    do_reset();
    mode_sel = 2'b00; out_mode = 2'b00;
    run(5);
    repeat (10) @(negedge clk);
    chk("R1 hold", count, 8'h05);

    // R4 held compare in fast PWM: old value 0 stays active until 0xFF
    do_reset();
    mode_sel = 2'b11;
    write_cmp(8'h10);
    run(1);
    chk("R4 old match", match_flag, 1);
    match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
    chk("R6 match cleared", match_flag, 0);
    run(16);
    chk("R4 count", count, 8'h11);
    chk("R4 buffered no match", match_flag, 0);

    // R4 immediate compare in free-running mode
    do_reset();
    mode_sel = 2'b00;
    write_cmp(8'h10);
    run(17);
    chk("R4 immediate match", match_flag, 1);

    // R6 set beats clear, then clear alone
    do_reset();
    mode_sel = 2'b00;
    run(255);
    chk("R5 not yet", ovf_flag, 0);
    tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    tick = 1'b0; ovf_clr = 1'b0;
    chk("R6 set wins", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R6 cleared", ovf_flag, 0);

    // R12 reset mid-run clears active compare too
    do_reset();
    mode_sel = 2'b00; out_mode = 2'b01;
    write_cmp(8'h05);
    run(6);
    chk("R7 pre-reset wave", wave_out, 1);
    do_reset();
    chk("R12 wave cleared", wave_out, 0);
    chk("R12 count cleared", count, 0);
    run(1);
    chk("R12 compare cleared", match_flag, 1);
    chk("R7 toggle at zero", wave_out, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule